// File: doc/BRIEF.md
# Configurable Serial Character Transmitter

This block turns one character at a time into an asynchronous serial frame on a single output line. A baud-rate enable input pulses sixteen times per bit period, and all bit timing is counted in those pulses. The host offers a byte with a valid/ready handshake. Four configuration inputs control the frame. They select 5 to 8 data bits, turn parity on or off, choose odd or even parity, and choose a short or long stop period.

Each frame starts with a low start bit. The data bits follow, least significant first. An optional parity bit comes next, then a high stop period. With the long stop setting, the stop period is two bit times for words of 6 to 8 bits and one and a half bit times for 5-bit words. The block captures the configuration and the byte at the moment it accepts the byte. The host may change its inputs while a frame is in progress without affecting that frame. A busy flag is high while a frame is being sent.

Top module: `async_ser_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx_line` is 1, `in_ready` is 1 and `busy` is 0.
- R2: A byte is accepted on a clock edge where `in_valid` and `in_ready` are both 1. From the next cycle, `tx_line` is 0 for 16 `tick16` pulses (the start bit). A tick on the accepting edge itself is not counted.
- R3: The data bits follow the start bit, least significant bit first, each lasting 16 ticks. `cfg_wlen` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8.
- R4: With `cfg_par_en`=1 and `cfg_par_even`=0, one parity bit of 16 ticks follows the data. It makes the count of ones over the data bits plus the parity bit odd.
- R5: With `cfg_par_en`=1 and `cfg_par_even`=1, the parity bit makes that count even. For example, 8-bit data 0xAA gives parity 0 and 0xAB gives parity 1.
- R6: With `cfg_par_en`=0, no parity bit is sent, whatever the value of `cfg_par_even`. The stop period follows the last data bit directly.
- R7: The stop period holds `tx_line` at 1. It lasts 16 ticks when `cfg_stop2`=0, 24 ticks when `cfg_stop2`=1 with a 5-bit word, and 32 ticks when `cfg_stop2`=1 with a 6-, 7- or 8-bit word.
- R8: `in_ready` is 0 and `busy` is 1 from the cycle after acceptance until the stop period has completed. `in_valid` has no effect while `in_ready` is 0.
- R9: Bits of `in_data` above the configured word length are neither sent nor counted in the parity.
- R10: Changes to the configuration inputs after acceptance do not affect the frame in progress.
- R11: `tx_line` changes only on a clock edge that accepts a byte or on which `tick16` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Baud enable pulse, 16 per bit time |
| cfg_wlen | input | 2 | Word length select (0..3 means 5..8 bits) |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_even | input | 1 | 1 selects even parity, 0 selects odd |
| cfg_stop2 | input | 1 | Long stop period select |
| in_valid | input | 1 | Host offers a byte |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Block can accept a byte |
| tx_line | output | 1 | Serial output, idles high |
| busy | output | 1 | Frame in progress |

## Verification
`tx_line` changes in the cycle right after the accepting edge and right after a counted tick edge. `in_ready` and `busy` change in the cycle after acceptance and in the cycle after the tick that ends the stop period. The bench model applies each edge's effect at that edge and compares all three outputs at the following falling edge. It builds the whole frame as a list of levels, one per tick, when it sees acceptance, and it drops one level per tick edge. A late or early transition by even one tick therefore shows up as a mismatch. The tick rate is varied, and the configuration is scrambled during a frame, to show that the timing is counted in ticks and that the settings are held from acceptance.

// File: rtl/ast_pkg.sv
package ast_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } ast_state_e;

  // Mask that keeps only the configured number of data bits (5 + wl).
  function automatic logic [BYTE_W-1:0] keep_mask(input logic [1:0] wl);
    return 8'hFF >> (2'd3 - wl);
  endfunction

  // Index of the last data bit sent (4..7).
  function automatic logic [2:0] last_index(input logic [1:0] wl);
    return {1'b1, wl};
  endfunction

  // Parity bit: the XOR of the kept bits, inverted for the odd setting.
  function automatic logic parity_of(input logic [BYTE_W-1:0] d,
                                     input logic [1:0] wl,
                                     input logic even_sel);
    return (^(d & keep_mask(wl))) ^ ~even_sel;
  endfunction

  // Length of the stop period in ticks.
  function automatic int unsigned stop_len(input logic [1:0] wl,
                                           input logic long_stop,
                                           input int unsigned tpb);
    if (!long_stop) return tpb;
    if (wl == 2'd0) return tpb + tpb / 2;
    return 2 * tpb;
  endfunction

endpackage

// File: rtl/ast_bit_timer.sv
module ast_bit_timer #(
  parameter int unsigned CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          restart,
  input  logic [CW-1:0] limit,
  output logic          done
);

  logic [CW-1:0] cnt;

  assign done = tick && !restart && (cnt == limit - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (restart || done)  cnt <= '0;
    else if (tick)             cnt <= cnt + CW'(1);
  end

endmodule

// File: rtl/ast_frame_fsm.sv
module ast_frame_fsm
  import ast_pkg::*;
#(
  parameter int unsigned TPB = 16,
  parameter int unsigned CW  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [BYTE_W-1:0] in_data,
  input  logic [1:0]        cfg_wlen,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic              cfg_stop2,
  input  logic              bit_done,
  output logic [CW-1:0]     bit_limit,
  output logic              line,
  output logic              idle,
  output logic              frame_done
);

  ast_state_e        state;
  logic [BYTE_W-1:0] shreg;
  logic [2:0]        idx;
  logic [2:0]        last_idx;
  logic              par_en_q;
  logic              par_q;
  logic [CW-1:0]     stop_lim_q;

  assign idle       = (state == ST_IDLE);
  assign frame_done = (state == ST_STOP) && bit_done;
  assign bit_limit  = (state == ST_STOP) ? stop_lim_q : CW'(TPB);

  always_comb begin
    unique case (state)
      ST_START:  line = 1'b0;
      ST_DATA:   line = shreg[0];
      ST_PARITY: line = par_q;
      default:   line = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      shreg      <= '0;
      idx        <= '0;
      last_idx   <= '0;
      par_en_q   <= 1'b0;
      par_q      <= 1'b0;
      stop_lim_q <= CW'(TPB);
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          shreg      <= in_data & keep_mask(cfg_wlen);
          last_idx   <= last_index(cfg_wlen);
          par_en_q   <= cfg_par_en;
          par_q      <= parity_of(in_data, cfg_wlen, cfg_par_even);
          stop_lim_q <= CW'(stop_len(cfg_wlen, cfg_stop2, TPB));
          state      <= ST_START;
        end
        ST_START: if (bit_done) begin
          idx   <= '0;
          state <= ST_DATA;
        end
        ST_DATA: if (bit_done) begin
          shreg <= shreg >> 1;
          idx   <= idx + 3'd1;
          if (idx == last_idx) state <= par_en_q ? ST_PARITY : ST_STOP;
        end
        ST_PARITY: if (bit_done) state <= ST_STOP;
        ST_STOP:   if (bit_done) state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/async_ser_tx.sv
module async_ser_tx
  import ast_pkg::*;
#(
  parameter int unsigned TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic [1:0]        cfg_wlen,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic              cfg_stop2,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  output logic              tx_line,
  output logic              busy
);

  localparam int unsigned CW = $clog2(2 * TICKS_PER_BIT + 1);

  // Named internal events, brought out for the checker.
  logic          accept;
  logic          bit_done;
  logic          frame_done;
  logic          idle;
  logic [CW-1:0] bit_limit;

  assign accept   = in_valid && idle;
  assign in_ready = idle;
  assign busy     = !idle;

  ast_bit_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick16),
    .restart (accept),
    .limit   (bit_limit),
    .done    (bit_done)
  );

  ast_frame_fsm #(.TPB(TICKS_PER_BIT), .CW(CW)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept),
    .in_data      (in_data),
    .cfg_wlen     (cfg_wlen),
    .cfg_par_en   (cfg_par_en),
    .cfg_par_even (cfg_par_even),
    .cfg_stop2    (cfg_stop2),
    .bit_done     (bit_done),
    .bit_limit    (bit_limit),
    .line         (tx_line),
    .idle         (idle),
    .frame_done   (frame_done)
  );

endmodule

// File: rtl/ast_tx_checks.sv
module ast_tx_checks (
  input logic clk,
  input logic rst_n,
  input logic tick16,
  input logic accept,
  input logic frame_done,
  input logic in_ready,
  input logic busy,
  input logic tx_line
);

  // R2: the start bit appears in the cycle after acceptance
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !tx_line);

  // R8: handshake closes right after acceptance
  a_r8_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!in_ready && busy));

  // R8: handshake reopens once the stop period ends
  a_r8_ready_returns: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (in_ready && !busy));

  // R7: the line is high in the last cycle of the stop period
  a_r7_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> tx_line);

  // R1: the line is high whenever no frame is in progress
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> tx_line);

  // R11: the line moves only after a tick or an acceptance
  a_r11_tick_timed: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick16 && !accept) |=> $stable(tx_line));

endmodule

bind async_ser_tx ast_tx_checks u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick16     (tick16),
  .accept     (accept),
  .frame_done (frame_done),
  .in_ready   (in_ready),
  .busy       (busy),
  .tx_line    (tx_line)
);

// File: tb/async_ser_tx_test.sv
module async_ser_tx_test;

  localparam int CLK_PERIOD = 10;
  localparam int TPB        = 16;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic [1:0] cfg_wlen = 2'd3;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_even = 1'b0;
  logic       cfg_stop2 = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, tx_line, busy;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int tick_period = 2;
  int tick_cnt = 0;
  bit finished = 1'b0;
  string extra_tag = "";

  always #(CLK_PERIOD / 2) clk = ~clk;

  async_ser_tx #(.TICKS_PER_BIT(TPB)) uut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en),
    .cfg_par_even(cfg_par_even), .cfg_stop2(cfg_stop2),
    .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .tx_line(tx_line), .busy(busy)
  );

  // Tick generator: one pulse every tick_period cycles.
  always @(posedge clk) begin
    #1;
    tick_cnt = (tick_cnt + 1) % tick_period;
    tick16 = (tick_cnt == 0);
  end

  // Reference model: a list of expected line levels, one per tick.
  bit    lvl_q[$];
  string tag_q[$];

  task automatic push_run(input bit v, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      lvl_q.push_back(v);
      tag_q.push_back(tag);
    end
  endtask

  task automatic build_frame();
    int nbits, ones, stop_n;
    bit par, upper;
    nbits = 5 + int'(cfg_wlen);
    ones = 0;
    upper = 1'b0;
    for (int i = 0; i < 8; i++) if (i >= nbits && in_data[i]) upper = 1'b1;
    push_run(1'b0, TPB, {extra_tag, "R2 start bit (R11 tick-timed)"});
    for (int i = 0; i < nbits; i++) begin
      if (in_data[i]) ones++;
      push_run(in_data[i], TPB, upper ? {extra_tag, "R9 masked data"} : {extra_tag, "R3 data bit"});
    end
    par = cfg_par_even ? (ones % 2 == 1) : (ones % 2 == 0);
    if (cfg_par_en)
      push_run(par, TPB, cfg_par_even ? {extra_tag, "R5 even parity"} : {extra_tag, "R4 odd parity"});
    if (!cfg_stop2)        stop_n = TPB;
    else if (nbits == 5)   stop_n = TPB + TPB / 2;
    else                   stop_n = 2 * TPB;
    push_run(1'b1, stop_n, cfg_par_en ? {extra_tag, "R7 stop period"} : {extra_tag, "R6 no parity, R7 stop period"});
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      lvl_q.delete();
      tag_q.delete();
    end else if (in_valid && lvl_q.size() == 0) begin
      build_frame();
    end else if (tick16 && lvl_q.size() > 0) begin
      void'(lvl_q.pop_front());
      void'(tag_q.pop_front());
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Compare on every falling edge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit exp_line;
      bit exp_idle;
      string tag;
      exp_idle = (lvl_q.size() == 0);
      exp_line = exp_idle ? 1'b1 : lvl_q[0];
      tag = exp_idle ? "R1 idle line" : tag_q[0];
      check(tx_line == exp_line, tag, int'(tx_line), int'(exp_line));
      check(in_ready == exp_idle, "R8 ready", int'(in_ready), int'(exp_idle));
      check(busy == !exp_idle, "R8 busy", int'(busy), int'(!exp_idle));
    end
  end

  task automatic finish_run();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !finished) begin
      failures++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, WATCHDOG);
      finish_run();
    end
  end

  task automatic wait_idle();
    do @(negedge clk); while (!in_ready);
  endtask

  // Send one byte; optionally scramble the configuration or hold valid afterwards.
  task automatic send(input logic [7:0] d, input logic [1:0] wl, input bit pe,
                      input bit ev, input bit st, input bit scramble, input int hold);
    cfg_wlen = wl; cfg_par_en = pe; cfg_par_even = ev; cfg_stop2 = st;
    in_data = d;
    in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk);
    #2;
    if (scramble) begin
      cfg_wlen = ~wl; cfg_par_en = ~pe; cfg_par_even = ~ev; cfg_stop2 = ~st;
      in_data = ~d;
    end
    if (hold > 0) begin
      in_data = 8'h3C;
      repeat (hold) @(posedge clk);
      #2;
    end
    in_valid = 1'b0;
    wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check(tx_line == 1'b1, "R1 reset line", int'(tx_line), 1);
    check(in_ready == 1'b1, "R1 reset ready", int'(in_ready), 1);
    check(busy == 1'b0, "R1 reset busy", int'(busy), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    send(8'hAA, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 0);   // R4 odd parity
    send(8'hAA, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 0);   // R5 even, parity 0
    send(8'hAB, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 0);   // R5 even, parity 1
    send(8'h55, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 0);   // R6 no parity, R7 2 stop
    send(8'hF3, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 0);   // R9 upper bits, R7 1.5 stop
    send(8'h2D, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 0);   // R3 6-bit word
    extra_tag = "R10 cfg held: ";
    send(8'h96, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 0);   // R10 scrambled after accept
    extra_tag = "R8 valid ignored: ";
    send(8'h5A, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 40);  // R8 valid held while busy
    extra_tag = "";
    tick_period = 1;
    send(8'h81, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 0);   // R11 tick every cycle
    tick_period = 3;
    send(8'h0F, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 0);   // R7 1.5 stop, slow ticks
    send(8'hE7, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 0);   // R5 7-bit word
    repeat (10) @(negedge clk);
    finish_run();
  end

endmodule